// File: doc/BRIEF.md
# Converter Start-Up Mode Sequencer

This block governs how a multichannel audio converter comes out of reset. Once the reset input is released it holds the converter in a low-power state while it counts rising edges of the left/right frame clock. The length of that wait depends on the sampling speed. If the control-port enable bit is written during the wait, the converter is driven from its register settings. If the wait runs out with no such write, the block adopts the four strap pins as its settings and begins powering up without further help.

In register-driven operation the power-down bit keeps the converter in low power, so settings can be loaded first. Clearing that bit starts a fixed power-up delay, after which the ready flag rises. Setting it again puts the converter back into low power without repeating the start-up wait. An enable write that arrives late, after the strap-driven sequence has already started, still moves the converter to register-driven operation.

The frame clock is asynchronous to the system clock. It passes through a two-flop synchronizer, and each rising edge advances the wait counter once. The speed code is sampled on the first clock after reset release and held for the rest of that wait.

Top module: `conv_startup_seq`

## Requirements
- R1: While reset is low, and right after it, `op_mode` is 2'b00 (undecided), `low_power` is 1, `ready` is 0 and `applied_cfg` is 0.
- R2: The start-up wait lasts `BASE_FRAMES` frame-clock rising edges for `speed_code` 2'b00, twice that for 2'b01, and four times that for 2'b10 or 2'b11. Up to the last edge, `low_power` stays 1 and `op_mode` stays 2'b00.
- R3: An enable write (`cp_en_wr` high for one clock) during the wait sets `op_mode` to 2'b10 (register-driven) on the next clock. `low_power` stays 1, and frame edges counted afterwards have no effect.
- R4: If the wait ends with no enable write, `op_mode` becomes 2'b01 (strap-driven), `applied_cfg` equals `mode_pins`, and `low_power` falls to 0 as the power-up delay starts.
- R5: An enable write while `op_mode` is 2'b01, whether during the power-up delay or after `ready`, sets `op_mode` to 2'b10 on the next clock, raises `low_power` and clears `ready`.
- R6: In register-driven operation, `applied_cfg` equals `sw_cfg`. While `pd_bit` is 1, `low_power` stays 1 and `ready` stays 0.
- R7: After the power-up delay starts, `ready` rises exactly `PWRUP_CYCLES` clocks later and not before. While `ready` is 1, `low_power` is 0.
- R8: In register-driven operation, raising `pd_bit` during the delay or after `ready` returns the block to low power on the next clock and clears `ready`. A later clear of `pd_bit` starts a new delay with no new frame wait.
- R9: A change of `speed_code` after reset release does not alter the current wait length. It takes effect at the next reset release.
- R10: An enable write while `op_mode` is already 2'b10 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_clk | input | 1 | Left/right frame clock, asynchronous to clk |
| speed_code | input | 2 | 00 single, 01 double, 10/11 quad speed |
| cp_en_wr | input | 1 | One-clock strobe: control-port enable bit written |
| pd_bit | input | 1 | Power-down register bit (1 = stay powered down) |
| mode_pins | input | CFG_W | Strap pins used as settings in strap-driven operation |
| sw_cfg | input | CFG_W | Register settings used in register-driven operation |
| op_mode | output | 2 | 00 undecided, 01 strap-driven, 10 register-driven |
| applied_cfg | output | CFG_W | Settings currently applied |
| low_power | output | 1 | Converter held in low power |
| ready | output | 1 | Power-up complete, conversion enabled |

## Verification
The bench builds the block with `BASE_FRAMES` = 8 and `PWRUP_CYCLES` = 20, in place of the defaults of 512 frames and 6250 clocks. That puts all three speed-dependent waits and the exact last-edge boundary of each within a few hundred clocks. Each run can then also reach the late enable takeover, repeated power-down and power-up cycles, and the mid-wait speed change across a second reset release. The short delay also lets the bench probe the cycle just before `ready` may rise as well as the cycle when it must.

// File: rtl/startup_pkg.sv
package startup_pkg;

  typedef enum logic [1:0] {
    OPM_NONE = 2'b00,
    OPM_HW   = 2'b01,
    OPM_SW   = 2'b10
  } opmode_t;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'b00,
    ST_SWIDL = 2'b01,
    ST_RAMP  = 2'b10,
    ST_ON    = 2'b11
  } seqst_t;

  // Frame-count multiplier as a left shift of the base count.
  function automatic int unsigned speed_shift(input logic [1:0] code);
    case (code)
      2'b00:   speed_shift = 0;
      2'b01:   speed_shift = 1;
      default: speed_shift = 2;
    endcase
  endfunction

endpackage

// File: rtl/frame_edge_sync.sv
module frame_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_i,
  output logic rise_o
);

  // SYNC_STAGES flops bring the level in; one more flop keeps the previous level.
  logic [SYNC_STAGES:0] pipe_q;
  logic [SYNC_STAGES:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[SYNC_STAGES-1:0], frame_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign rise_o = pipe_q[SYNC_STAGES-1] & ~pipe_q[SYNC_STAGES];

endmodule

// File: rtl/frame_timeout.sv
module frame_timeout
  import startup_pkg::*;
#(
  parameter int BASE_FRAMES = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_i,
  input  logic       edge_i,
  input  logic [1:0] speed_i,
  output logic       expire_o
);

  localparam int MAX_FRAMES = BASE_FRAMES * 4;
  localparam int CW         = $clog2(MAX_FRAMES + 1);

  logic          armed_q;
  logic [1:0]    spd_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic [CW-1:0] last_idx;
  logic          spd_en;
  logic          cnt_en;

  // The speed code is sampled once, on the first clock after reset release.
  assign spd_en = ~armed_q;

  always_comb begin
    last_idx = CW'((BASE_FRAMES << speed_shift(spd_q)) - 1);
  end

  assign cnt_en   = run_i & armed_q & edge_i;
  assign expire_o = cnt_en & (cnt_q == last_idx);

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en && !expire_o) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spd_q <= 2'b00;
    end else if (spd_en) begin
      spd_q <= speed_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/pwrup_timer.sv
module pwrup_timer #(
  parameter int PWRUP_CYCLES = 6250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic done_o
);

  localparam int TW = $clog2(PWRUP_CYCLES + 1);
  localparam logic [TW-1:0] LAST = TW'(PWRUP_CYCLES - 1);

  logic [TW-1:0] tcnt_q;
  logic [TW-1:0] tcnt_d;

  assign done_o = run_i & (tcnt_q == LAST);

  // Clears whenever the ramp is not running, so every ramp starts from zero.
  always_comb begin
    if (!run_i) begin
      tcnt_d = '0;
    end else if (done_o) begin
      tcnt_d = tcnt_q;
    end else begin
      tcnt_d = tcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q <= '0;
    end else begin
      tcnt_q <= tcnt_d;
    end
  end

endmodule

// File: rtl/conv_startup_seq.sv
module conv_startup_seq
  import startup_pkg::*;
#(
  parameter int BASE_FRAMES  = 512,
  parameter int PWRUP_CYCLES = 6250,
  parameter int CFG_W        = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_clk,
  input  logic [1:0]       speed_code,
  input  logic             cp_en_wr,
  input  logic             pd_bit,
  input  logic [CFG_W-1:0] mode_pins,
  input  logic [CFG_W-1:0] sw_cfg,
  output logic [1:0]       op_mode,
  output logic [CFG_W-1:0] applied_cfg,
  output logic             low_power,
  output logic             ready
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rsync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end

  assign srst_n = rsync_q[1];

  logic    frame_rise;
  logic    wait_run;
  logic    wait_expire;
  logic    ramp_run;
  logic    ramp_done;
  seqst_t  st_q, st_d;
  opmode_t mode_q, mode_d;

  frame_edge_sync #(
    .SYNC_STAGES(2)
  ) u_edge (
    .clk    (clk),
    .rst_n  (srst_n),
    .frame_i(frame_clk),
    .rise_o (frame_rise)
  );

  assign wait_run = (st_q == ST_HOLD);

  frame_timeout #(
    .BASE_FRAMES(BASE_FRAMES)
  ) u_wait (
    .clk     (clk),
    .rst_n   (srst_n),
    .run_i   (wait_run),
    .edge_i  (frame_rise),
    .speed_i (speed_code),
    .expire_o(wait_expire)
  );

  assign ramp_run = (st_q == ST_RAMP);

  pwrup_timer #(
    .PWRUP_CYCLES(PWRUP_CYCLES)
  ) u_ramp (
    .clk   (clk),
    .rst_n (srst_n),
    .run_i (ramp_run),
    .done_o(ramp_done)
  );

  // Next-state logic
  always_comb begin
    st_d   = st_q;
    mode_d = mode_q;
    if (cp_en_wr && (mode_q != OPM_SW)) begin
      // An enable write takes over at any point, including a late one
      mode_d = OPM_SW;
      st_d   = ST_SWIDL;
    end else begin
      case (st_q)
        ST_HOLD: begin
          if (wait_expire) begin
            mode_d = OPM_HW;
            st_d   = ST_RAMP;
          end
        end
        ST_SWIDL: begin
          if (!pd_bit) begin
            st_d = ST_RAMP;
          end
        end
        ST_RAMP: begin
          if ((mode_q == OPM_SW) && pd_bit) begin
            st_d = ST_SWIDL;
          end else if (ramp_done) begin
            st_d = ST_ON;
          end
        end
        ST_ON: begin
          if ((mode_q == OPM_SW) && pd_bit) begin
            st_d = ST_SWIDL;
          end
        end
        default: st_d = ST_HOLD;
      endcase
    end
  end

  // State registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q   <= ST_HOLD;
      mode_q <= OPM_NONE;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
    end
  end

  // Outputs
  always_comb begin
    case (mode_q)
      OPM_HW:  applied_cfg = mode_pins;
      OPM_SW:  applied_cfg = sw_cfg;
      default: applied_cfg = '0;
    endcase
  end

  assign op_mode   = mode_q;
  assign low_power = (st_q == ST_HOLD) || (st_q == ST_SWIDL);
  assign ready     = (st_q == ST_ON);

endmodule

// File: rtl/conv_startup_chk.sv
module conv_startup_chk #(
  parameter int CFG_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cp_en_wr,
  input logic             pd_bit,
  input logic [1:0]       op_mode,
  input logic [CFG_W-1:0] applied_cfg,
  input logic             low_power,
  input logic             ready
);

  // R1: no decision yet means powered down and not ready
  assert_undecided_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode == 2'b00) |-> (low_power && !ready && (applied_cfg == '0)));

  // R3 / R5: an enable write hands control to the registers on the next clock
  assert_enable_takeover_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_en_wr && (op_mode != 2'b10)) |=> ((op_mode == 2'b10) && low_power && !ready));

  // R4: leaving the undecided state for strap mode starts the ramp at once
  assert_strap_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_mode == 2'b00) ##1 (op_mode == 2'b01)) |-> !low_power);

  // R10: register-driven operation never falls back
  assert_sw_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode == 2'b10) |=> (op_mode == 2'b10));

  // R7: ready and low power never coincide
  assert_ready_powered_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !low_power);

  // R8: setting power-down in register mode drops back to low power
  assert_pd_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_mode == 2'b10) && pd_bit && !low_power && !cp_en_wr) |=> (low_power && !ready));

  // R6: held power-down keeps the converter idle in register mode
  assert_pd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_mode == 2'b10) && low_power && pd_bit) |=> (low_power && !ready));

endmodule

bind conv_startup_seq conv_startup_chk #(
  .CFG_W(CFG_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cp_en_wr   (cp_en_wr),
  .pd_bit     (pd_bit),
  .op_mode    (op_mode),
  .applied_cfg(applied_cfg),
  .low_power  (low_power),
  .ready      (ready)
);

// File: tb/conv_startup_seq_test.sv
`timescale 1ns/1ps
module conv_startup_seq_test;

  localparam int BASE  = 8;
  localparam int PWR   = 20;
  localparam int CFG_W = 4;

  logic             clk;
  logic             rst_n;
  logic             frame_clk;
  logic [1:0]       speed_code;
  logic             cp_en_wr;
  logic             pd_bit;
  logic [CFG_W-1:0] mode_pins;
  logic [CFG_W-1:0] sw_cfg;
  logic [1:0]       op_mode;
  logic [CFG_W-1:0] applied_cfg;
  logic             low_power;
  logic             ready;

  int n_chk;
  int n_bad;
  bit finished;

  conv_startup_seq #(
    .BASE_FRAMES (BASE),
    .PWRUP_CYCLES(PWR),
    .CFG_W       (CFG_W)
  ) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_clk  (frame_clk),
    .speed_code (speed_code),
    .cp_en_wr   (cp_en_wr),
    .pd_bit     (pd_bit),
    .mode_pins  (mode_pins),
    .sw_cfg     (sw_cfg),
    .op_mode    (op_mode),
    .applied_cfg(applied_cfg),
    .low_power  (low_power),
    .ready      (ready)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One frame period: 4 clocks high, 4 low; the low half covers the synchronizer.
  task automatic frames(input int n);
    for (int i = 0; i < n; i++) begin
      frame_clk = 1'b1;
      cycles(4);
      frame_clk = 1'b0;
      cycles(4);
    end
  endtask

  task automatic write_enable();
    cp_en_wr = 1'b1;
    cycles(1);
    cp_en_wr = 1'b0;
  endtask

  task automatic do_reset(input logic [1:0] spd);
    rst_n      = 1'b0;
    frame_clk  = 1'b0;
    cp_en_wr   = 1'b0;
    pd_bit     = 1'b1;
    speed_code = spd;
    cycles(3);
    check("R1 op_mode in reset", 32'(op_mode), 32'h0);
    check("R1 low_power in reset", 32'(low_power), 32'h1);
    check("R1 ready in reset", 32'(ready), 32'h0);
    check("R1 cfg in reset", 32'(applied_cfg), 32'h0);
    rst_n = 1'b1;
    cycles(3);
  endtask

  // R2 / R4: wait length per speed, then strap mode with automatic ramp
  task automatic t_strap(input logic [1:0] spd, input int nfr, input logic [3:0] pins);
    mode_pins = pins;
    do_reset(spd);
    frames(nfr - 1);
    check("R2 still waiting low_power", 32'(low_power), 32'h1);
    check("R2 still undecided", 32'(op_mode), 32'h0);
    frames(1);
    check("R4 strap mode", 32'(op_mode), 32'h1);
    check("R4 ramp out of low power", 32'(low_power), 32'h0);
    check("R4 pins applied", 32'(applied_cfg), 32'(pins));
    check("R7 not ready early", 32'(ready), 32'h0);
    cycles(PWR);
    check("R7 ready after ramp", 32'(ready), 32'h1);
  endtask

  // R3 / R6 / R7 / R8 / R10: register-driven path
  task automatic t_soft();
    sw_cfg    = 4'h5;
    mode_pins = 4'hC;
    do_reset(2'b00);
    frames(3);
    write_enable();
    check("R3 register mode", 32'(op_mode), 32'h2);
    check("R3 low power held", 32'(low_power), 32'h1);
    frames(BASE + 2);
    check("R3 frames after enable ignored", 32'(op_mode), 32'h2);
    check("R6 pd holds low power", 32'(low_power), 32'h1);
    check("R6 pd holds not ready", 32'(ready), 32'h0);
    check("R6 sw cfg applied", 32'(applied_cfg), 32'h5);
    pd_bit = 1'b0;
    cycles(1);
    check("R7 ramp started", 32'(low_power), 32'h0);
    // Ramp state entered at the edge before this sample; ready is due PWR clocks on.
    cycles(PWR - 1);
    check("R7 ready not one clock early", 32'(ready), 32'h0);
    cycles(1);
    check("R7 ready on time", 32'(ready), 32'h1);
    write_enable();
    check("R10 repeated enable ready", 32'(ready), 32'h1);
    check("R10 repeated enable mode", 32'(op_mode), 32'h2);
    check("R10 repeated enable low_power", 32'(low_power), 32'h0);
    pd_bit = 1'b1;
    cycles(1);
    check("R8 back to low power", 32'(low_power), 32'h1);
    check("R8 ready cleared", 32'(ready), 32'h0);
    cycles(5);
    check("R8 stays low power without new wait", 32'(low_power), 32'h1);
    pd_bit = 1'b0;
    cycles(PWR + 2);
    check("R8 ready again without frames", 32'(ready), 32'h1);
    pd_bit = 1'b1;
    cycles(1);
    pd_bit = 1'b0;
    cycles(5);
    pd_bit = 1'b1;
    cycles(1);
    check("R8 pd during ramp returns low power", 32'(low_power), 32'h1);
    pd_bit = 1'b1;
  endtask

  // R5: late enable after strap sequence started
  task automatic t_late();
    mode_pins = 4'h9;
    sw_cfg    = 4'h3;
    do_reset(2'b00);
    frames(BASE);
    cycles(PWR);
    check("R5 strap ready first", 32'(ready), 32'h1);
    write_enable();
    check("R5 late enable mode", 32'(op_mode), 32'h2);
    check("R5 late enable low power", 32'(low_power), 32'h1);
    check("R5 late enable not ready", 32'(ready), 32'h0);
    check("R5 late enable cfg", 32'(applied_cfg), 32'h3);
    do_reset(2'b00);
    frames(BASE);
    cycles(3);
    write_enable();
    check("R5 enable during ramp mode", 32'(op_mode), 32'h2);
    check("R5 enable during ramp low power", 32'(low_power), 32'h1);
  endtask

  // R9: mid-wait speed change ignored until next reset release
  task automatic t_speed_change();
    mode_pins = 4'h6;
    do_reset(2'b00);
    frames(2);
    speed_code = 2'b10;
    frames(BASE - 3);
    check("R9 still waiting", 32'(low_power), 32'h1);
    frames(1);
    check("R9 old speed limit used", 32'(op_mode), 32'h1);
    do_reset(2'b10);
    frames(BASE * 4 - 1);
    check("R9 new speed after reset waiting", 32'(op_mode), 32'h0);
    frames(1);
    check("R9 new speed after reset expired", 32'(op_mode), 32'h1);
  endtask

  initial begin
    n_chk      = 0;
    n_bad      = 0;
    finished   = 1'b0;
    rst_n      = 1'b0;
    frame_clk  = 1'b0;
    cp_en_wr   = 1'b0;
    pd_bit     = 1'b1;
    speed_code = 2'b00;
    mode_pins  = '0;
    sw_cfg     = '0;
    t_strap(2'b00, BASE,     4'hA);
    t_strap(2'b01, BASE * 2, 4'h7);
    t_strap(2'b10, BASE * 4, 4'h1);
    t_strap(2'b11, BASE * 4, 4'hE);
    t_soft();
    t_late();
    t_speed_change();
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule